// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one data word per valid/ready handshake into an asynchronous serial frame on a single output line. A frame is a start bit, then 5 to 9 data bits, then an optional parity bit, then a stop period of selectable length. The receiving side is expected to agree on the same bit period and framing in advance.

The bit period is set at run time as a half-bit length in clock cycles. All timing runs on half-bit ticks, so the stop period can last half a bit, one bit, one and a half bits or two bits. Further run-time choices are the data length, the parity mode, the data bit order and two inversion options. The first inverts the whole line, which also makes the line idle low. The second inverts only the data and parity bits.

All frame settings are captured in the cycle a word is accepted. They then apply unchanged to that whole frame, so the settings inputs may change while a frame is being sent. A new word can be taken in the last cycle of the stop period, which lets frames follow each other with no idle gap.

Top module: `uart_frame_tx`

## Requirements
- R1: While reset is held, `tx_out` is 1 and `in_ready` is 1. With `cfg_inv_line` at 0, both stay 1 after reset until a word is accepted.
- R2: With no frame in progress, `tx_out` equals the inverse of `cfg_inv_line`, registered one cycle after it is sampled. An accepted word starts its start bit, which is logic 0 before any line inversion, in the cycle right after the accepting clock edge.
- R3: The number of data bits is `cfg_len`. Values below 5 are treated as 5, and values above 9 are treated as 9. With `cfg_msb_first` = 0, `in_data` bit 0 is sent first.
- R4: With `cfg_msb_first` = 1, the data bits are sent from bit (length-1) down to bit 0.
- R5: `cfg_parity` selects the parity bit: 0 = none, 1 = odd, 2 = even, 3 = always 1, 4 = always 0, and 5 to 7 = none. For odd and even, the number of ones in the sent data bits plus the parity bit is odd or even respectively. The parity bit follows the last data bit.
- R6: `cfg_stop` selects the stop period at logic 1: 0 = half a bit, 1 = one bit, 2 = one and a half bits, 3 = two bits.
- R7: With `cfg_inv_line` = 1, every level of the frame is inverted, and so is the idle level.
- R8: With `cfg_inv_data` = 1, the data bits and the parity bit are inverted, while the start and stop levels are not. Parity is computed on the data before inversion.
- R9: `in_ready` is 0 from the accepting edge until the last cycle of the stop period, and `in_valid` has no effect meanwhile. In that last cycle `in_ready` is 1, and a word offered then starts its start bit in the very next cycle.
- R10: Changes to `in_data` and to any settings input during a frame do not alter that frame.
- R11: A half bit lasts `cfg_half`+1 cycles, and every data, start or parity bit lasts two half bits. `tx_out` changes only on half-bit boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block takes the offered word at this edge |
| in_data | input | 9 | Word to send; bits above the data length are ignored |
| cfg_half | input | 16 | Half-bit length minus one, in cycles |
| cfg_len | input | 4 | Data bit count, clamped to 5..9 |
| cfg_parity | input | 3 | Parity mode code |
| cfg_stop | input | 2 | Stop period code |
| cfg_msb_first | input | 1 | Send the top data bit first |
| cfg_inv_line | input | 1 | Invert the whole line |
| cfg_inv_data | input | 1 | Invert data and parity bits only |
| tx_out | output | 1 | Serial line, registered |

## Verification
The start level is due in the first cycle after the accepting edge. After that, cycle c of the frame must show the level of half bit c/(cfg_half+1), and `in_ready` must rise only in cycle N-1 of an N-cycle frame. The bench builds the expected level for every half bit before each frame and counts cycles from the accepting edge. It samples at falling edges and compares every cycle against that plan. The idle level is checked one cycle after the final edge, and a back-to-back word is offered exactly in the last stop cycle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_t;

  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_EVEN  = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;
  localparam logic [2:0] PAR_SPACE = 3'd4;

  // stop code 0..3 -> 1..4 half bits
  function automatic logic [2:0] stop_halves(input logic [1:0] code);
    return {1'b0, code} + 3'd1;
  endfunction
endpackage

// File: rtl/uart_tx_tick.sv
module uart_tx_tick #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          clr,
  input  logic [CW-1:0] period,
  output logic          tick,
  output logic [CW-1:0] count
);
  assign tick = run && (count == period);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (clr || !run || tick) begin
      count <= '0;
    end else begin
      count <= count + CW'(1);
    end
  end
endmodule

// File: rtl/uart_tx_build.sv
module uart_tx_build #(
  parameter int DATA_W  = 9,
  parameter int LEN_W   = 4,
  parameter int MIN_LEN = 5
) (
  input  logic [DATA_W-1:0] data,
  input  logic [LEN_W-1:0]  len_req,
  input  logic              msb_first,
  input  logic [2:0]        par_mode,
  output logic [DATA_W-1:0] ordered,
  output logic [LEN_W-1:0]  len_eff,
  output logic              has_par,
  output logic              par_bit
);
  import uart_tx_pkg::*;

  logic [DATA_W-1:0] mask;
  logic              ones_odd;

  always_comb begin
    if (len_req < LEN_W'(MIN_LEN))      len_eff = LEN_W'(MIN_LEN);
    else if (len_req > LEN_W'(DATA_W))  len_eff = LEN_W'(DATA_W);
    else                                len_eff = len_req;
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      logic [LEN_W-1:0] j;
      j          = len_eff - LEN_W'(1) - LEN_W'(i);
      mask[i]    = (i < int'(len_eff));
      ordered[i] = 1'b0;
      if (i < int'(len_eff)) begin
        ordered[i] = msb_first ? data[j] : data[i];
      end
    end
  end

  assign ones_odd = ^(data & mask);

  always_comb begin
    has_par = 1'b1;
    par_bit = 1'b0;
    case (par_mode)
      PAR_ODD:   par_bit = ~ones_odd;
      PAR_EVEN:  par_bit = ones_odd;
      PAR_MARK:  par_bit = 1'b1;
      PAR_SPACE: par_bit = 1'b0;
      default:   has_par = 1'b0;
    endcase
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DATA_W = 9,
  parameter int HALF_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [2:0]        cfg_parity,
  input  logic [1:0]        cfg_stop,
  input  logic              cfg_msb_first,
  input  logic              cfg_inv_line,
  input  logic              cfg_inv_data,
  output logic              tx_out
);
  import uart_tx_pkg::*;

  localparam int HIDX_W = 3;

  tx_state_t          st, n_st;
  logic [HIDX_W-1:0]  hidx, n_hidx, last_half;
  logic [LEN_W-1:0]   bidx, n_bidx;
  logic [DATA_W-1:0]  shreg, n_sh;
  logic [HALF_W-1:0]  l_half, n_half;
  logic [LEN_W-1:0]   l_len, n_len;
  logic [HIDX_W-1:0]  l_stoph, n_stoph;
  logic               l_haspar, n_haspar, l_par, n_par;
  logic               l_invl, n_invl, l_invd, n_invd;
  logic               tx_q, n_lvl;

  logic               busy, tick, bit_end, accept, data_phase;
  logic [HALF_W-1:0]  half_cnt;

  logic [DATA_W-1:0]  b_ordered;
  logic [LEN_W-1:0]   b_len;
  logic               b_haspar, b_par;

  uart_tx_build #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(5)) u_build (
    .data(in_data), .len_req(cfg_len), .msb_first(cfg_msb_first),
    .par_mode(cfg_parity), .ordered(b_ordered), .len_eff(b_len),
    .has_par(b_haspar), .par_bit(b_par)
  );

  uart_tx_tick #(.CW(HALF_W)) u_tick (
    .clk(clk), .rst(rst), .run(busy), .clr(accept),
    .period(l_half), .tick(tick), .count(half_cnt)
  );

  assign busy       = (st != ST_IDLE);
  assign data_phase = (st == ST_DATA);
  assign last_half  = (st == ST_STOP) ? (l_stoph - HIDX_W'(1)) : HIDX_W'(1);
  assign bit_end    = tick && (hidx == last_half);
  assign in_ready   = !busy || ((st == ST_STOP) && bit_end);
  assign accept     = in_valid && in_ready;
  assign tx_out     = tx_q;

  always_comb begin
    n_st = st;  n_hidx = hidx;  n_bidx = bidx;  n_sh = shreg;
    n_half = l_half;  n_len = l_len;  n_stoph = l_stoph;
    n_haspar = l_haspar;  n_par = l_par;  n_invl = l_invl;  n_invd = l_invd;

    if (bit_end) begin
      n_hidx = '0;
      case (st)
        ST_START: begin
          n_st   = ST_DATA;
          n_bidx = '0;
        end
        ST_DATA: begin
          n_sh = shreg >> 1;
          if (bidx == l_len - LEN_W'(1)) n_st = l_haspar ? ST_PAR : ST_STOP;
          else                          n_bidx = bidx + LEN_W'(1);
        end
        ST_PAR:  n_st = ST_STOP;
        default: n_st = ST_IDLE;
      endcase
    end else if (tick) begin
      n_hidx = hidx + HIDX_W'(1);
    end

    if (accept) begin
      n_st     = ST_START;
      n_hidx   = '0;
      n_bidx   = '0;
      n_sh     = b_ordered;
      n_half   = cfg_half;
      n_len    = b_len;
      n_stoph  = stop_halves(cfg_stop);
      n_haspar = b_haspar;
      n_par    = b_par;
      n_invl   = cfg_inv_line;
      n_invd   = cfg_inv_data;
    end

    case (n_st)
      ST_START: n_lvl = n_invl;
      ST_DATA:  n_lvl = n_sh[0] ^ n_invd ^ n_invl;
      ST_PAR:   n_lvl = n_par ^ n_invd ^ n_invl;
      ST_STOP:  n_lvl = ~n_invl;
      default:  n_lvl = ~cfg_inv_line;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  hidx <= '0;  bidx <= '0;  shreg <= '0;
      l_half <= '0;  l_len <= LEN_W'(5);  l_stoph <= HIDX_W'(2);
      l_haspar <= 1'b0;  l_par <= 1'b0;  l_invl <= 1'b0;  l_invd <= 1'b0;
      tx_q <= 1'b1;
    end else begin
      st <= n_st;  hidx <= n_hidx;  bidx <= n_bidx;  shreg <= n_sh;
      l_half <= n_half;  l_len <= n_len;  l_stoph <= n_stoph;
      l_haspar <= n_haspar;  l_par <= n_par;  l_invl <= n_invl;  l_invd <= n_invd;
      tx_q <= n_lvl;
    end
  end
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk #(
  parameter int HALF_W = 16,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              tx_out,
  input logic              cfg_inv_line,
  input logic              busy,
  input logic              tick,
  input logic [HALF_W-1:0] cnt,
  input logic [HALF_W-1:0] half_lim,
  input logic              data_phase,
  input logic [LEN_W-1:0]  bidx,
  input logic [LEN_W-1:0]  blen
);
  AST_START_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (tx_out == $past(cfg_inv_line))); // R2

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready); // R9

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(tx_out)); // R11

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= half_lim)); // R11

  AST_BIT_INDEX: assert property (@(posedge clk) disable iff (rst)
    data_phase |-> (bidx < blen)); // R3
endmodule

bind uart_frame_tx uart_frame_tx_chk #(.HALF_W(HALF_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .tx_out(tx_out), .cfg_inv_line(cfg_inv_line), .busy(busy), .tick(tick),
  .cnt(half_cnt), .half_lim(l_half), .data_phase(data_phase),
  .bidx(bidx), .blen(l_len)
);

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [8:0]  in_data = '0;
  logic [15:0] cfg_half = 16'd1;
  logic [3:0]  cfg_len = 4'd8;
  logic [2:0]  cfg_parity = 3'd0;
  logic [1:0]  cfg_stop = 2'd1;
  logic        cfg_msb_first = 1'b0;
  logic        cfg_inv_line = 1'b0;
  logic        cfg_inv_data = 1'b0;
  logic        tx_out;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;
  bit  idle_inv = 1'b0;
  bit  exp_lv [0:31];
  int  exp_nh;

  always #5 clk = ~clk;

  uart_frame_tx i_uart_frame_tx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_half(cfg_half), .cfg_len(cfg_len),
    .cfg_parity(cfg_parity), .cfg_stop(cfg_stop), .cfg_msb_first(cfg_msb_first),
    .cfg_inv_line(cfg_inv_line), .cfg_inv_data(cfg_inv_data), .tx_out(tx_out)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // expected level of every half bit, from the requirements
  task automatic plan(input logic [8:0] d, input int lreq, input int par,
                      input int stp, input bit msb, input bit invl, input bit invd);
    int len, k, ones;
    bit b, p, hp;
    len = (lreq < 5) ? 5 : ((lreq > 9) ? 9 : lreq);
    k = 0; ones = 0;
    exp_lv[k++] = invl; exp_lv[k++] = invl;
    for (int i = 0; i < len; i++) begin
      b = msb ? d[len-1-i] : d[i];
      exp_lv[k++] = b ^ invd ^ invl;
      exp_lv[k++] = b ^ invd ^ invl;
      if (d[i]) ones++;
    end
    hp = 1'b1; p = 1'b0;
    case (par)
      1: p = (ones % 2) == 0;
      2: p = (ones % 2) == 1;
      3: p = 1'b1;
      4: p = 1'b0;
      default: hp = 1'b0;
    endcase
    if (hp) begin
      exp_lv[k++] = p ^ invd ^ invl;
      exp_lv[k++] = p ^ invd ^ invl;
    end
    for (int i = 0; i <= stp; i++) exp_lv[k++] = ~invl;
    exp_nh = k;
  endtask

  // called at a falling edge when in_ready is expected high
  task automatic send(input logic [8:0] d, input int half, input int lreq,
                      input int par, input int stp, input bit msb,
                      input bit invl, input bit invd, input string tag);
    int h, n, bad_lv, bad_rdy, fc, fa, fe, rc, ra;
    plan(d, lreq, par, stp, msb, invl, invd);
    chk(in_ready === 1'b1, "R9", "ready before offer", int'(in_ready), 1);
    in_data = d; cfg_half = 16'(half); cfg_len = 4'(lreq);
    cfg_parity = 3'(par); cfg_stop = 2'(stp); cfg_msb_first = msb;
    cfg_inv_line = invl; cfg_inv_data = invd; in_valid = 1'b1;
    @(posedge clk);
    h = half + 1; n = exp_nh * h;
    bad_lv = 0; bad_rdy = 0; fc = 0; fa = 0; fe = 0; rc = 0; ra = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (tx_out !== exp_lv[c / h]) begin
        if (bad_lv == 0) begin fc = c; fa = int'(tx_out); fe = int'(exp_lv[c / h]); end
        bad_lv++;
      end
      if (in_ready !== (c == n - 1)) begin
        if (bad_rdy == 0) begin rc = c; ra = int'(in_ready); end
        bad_rdy++;
      end
      if (c < n - 1) begin
        // R10: junk on data and settings during the frame, R9: valid ignored
        in_valid = 1'($urandom); in_data = 9'($urandom);
        cfg_half = 16'($urandom % 4); cfg_len = 4'($urandom);
        cfg_parity = 3'($urandom); cfg_stop = 2'($urandom);
        cfg_msb_first = 1'($urandom); cfg_inv_line = 1'($urandom);
        cfg_inv_data = 1'($urandom);
      end else begin
        in_valid = 1'b0; cfg_inv_line = idle_inv;
      end
    end
    chk(bad_lv == 0, tag, $sformatf("line level at frame cycle %0d", fc), fa, fe);
    chk(bad_rdy == 0, "R9", $sformatf("ready at frame cycle %0d", rc), ra, int'(rc == n - 1));
  endtask

  task automatic idle_check(input int cyc, input string tag);
    repeat (cyc) @(negedge clk);
    chk(tx_out === ~idle_inv, tag, "idle level", int'(tx_out), int'(~idle_inv));
    chk(in_ready === 1'b1, tag, "idle ready", int'(in_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(tx_out === 1'b1, "R1", "line in reset", int'(tx_out), 1);
    chk(in_ready === 1'b1, "R1", "ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(tx_out === 1'b1, "R1", "line after reset", int'(tx_out), 1);
    chk(in_ready === 1'b1, "R1", "ready after reset", int'(in_ready), 1);

    send(9'h05A, 1, 8, 0, 1, 0, 0, 0, "R3");          idle_check(2, "R2");
    send(9'h0C3, 1, 8, 0, 1, 1, 0, 0, "R4");          idle_check(1, "R2");
    send(9'h1F6, 0, 9, 0, 1, 1, 0, 0, "R4");          idle_check(1, "R2");
    send(9'h1B5, 1, 5, 0, 1, 0, 0, 0, "R3");          idle_check(1, "R3");
    send(9'h1B5, 1, 9, 0, 1, 0, 0, 0, "R3");          idle_check(1, "R3");
    send(9'h0AB, 1, 3, 0, 1, 0, 0, 0, "R3");          idle_check(1, "R3");
    send(9'h1AB, 1, 15, 0, 1, 0, 0, 0, "R3");         idle_check(1, "R3");
    for (int pm = 0; pm < 8; pm++) begin
      send(9'h0B1, 1, 8, pm, 1, 0, 0, 0, "R5");
      send(9'h0B3, 1, 7, pm, 1, 0, 0, 0, "R5");
    end
    idle_check(1, "R5");
    for (int sc = 0; sc < 4; sc++) begin
      send(9'h03C, 0, 6, 2, sc, 0, 0, 0, "R6");
      send(9'h03C, 2, 6, 0, sc, 0, 0, 0, "R6");
      idle_check(1, "R6");
    end
    idle_inv = 1'b1;
    send(9'h0E1, 1, 8, 1, 1, 0, 1, 0, "R7");          idle_check(2, "R7");
    send(9'h0E1, 1, 8, 2, 3, 1, 1, 1, "R7");          idle_check(1, "R7");
    idle_inv = 1'b0;
    cfg_inv_line = 1'b0;
    idle_check(2, "R7");
    send(9'h0E1, 1, 8, 1, 1, 0, 0, 1, "R8");
    send(9'h06D, 2, 7, 3, 2, 1, 0, 1, "R8");          idle_check(1, "R8");
    send(9'h155, 1, 9, 2, 0, 0, 0, 0, "R9");
    send(9'h0AA, 1, 8, 1, 0, 0, 0, 0, "R9");
    send(9'h0FF, 0, 5, 0, 2, 0, 1, 0, "R9");
    send(9'h001, 0, 5, 4, 0, 1, 0, 1, "R10");         idle_check(1, "R9");
    for (int hv = 0; hv < 6; hv++) send(9'h0A5, hv, 8, 0, 1, 0, 0, 0, "R11");
    idle_check(1, "R11");
    for (int t = 0; t < 40; t++) begin
      send(9'($urandom), int'($urandom % 4), int'($urandom % 16),
           int'($urandom % 8), int'($urandom % 4), 1'($urandom),
           1'($urandom), 1'($urandom), "R11");
      if (($urandom % 3) == 0) idle_check(1 + int'($urandom % 3), "R2");
    end
    idle_check(1, "R2");
    summary();
  end
endmodule